// File: doc/BRIEF.md
# Dual-CPU Handoff Register Bank

This block is a small byte-wide register bank shared by two processors: a host processor and a guest processor. Only one of them runs at a time. The host sees eight byte registers at offsets 0 to 7. The guest sees a private status byte, the shared control byte, and a read-only copy of the host status byte. The block holds the following:
- the run/reset handoff between the two CPUs;
- the video source and guest boot-map selects;
- a few mailbox bits mirrored from one side to the other;
- read-only switch inputs;
- a test mode in which the status byte returns a fixed rotating sequence.

Two state machines sit behind the registers. The handoff machine has the states `HO_HOST_RUNS` and `HO_GUEST_RUNS`. It moves to `HO_GUEST_RUNS` on the transition *grant* (control bit 0 seen set) and back to `HO_HOST_RUNS` on the transition *reclaim* (control bit 0 seen clear).

The sequence machine has the state `SQ_OFF` and eight entry states `SQ_E0` to `SQ_E7`. It has these transitions:
- *arm*: from `SQ_OFF` to `SQ_E0` when test mode is on.
- *step*: to the next entry state, wrapping from `SQ_E7` to `SQ_E0`, on a host read of the status byte.
- *quick step*: from `SQ_OFF` to `SQ_E1` when a host status read lands in the first test-mode cycle.
- *disarm*: from any state to `SQ_OFF` when test mode is off.

Each bus has an address, write data, a write strobe and a read strobe. Read data is registered. Bus decoding, the memory windows themselves and the CPUs lie outside the block.

Top module: `dual_cpu_handoff_regs`

## Requirements
- R1: After reset `guest_reset`=1 and `host_hold`=0. One clock after control bit 0 (host offset 4 or guest offset 1) is stored as 1, `guest_reset`=0 and `host_hold`=1. One clock after it is stored as 0, the outputs return to the reset values. The two outputs are never both 0.
- R2: Control bit 7 resets to 1. A host write to offset 4 can set it but not clear it. A guest write to guest offset 1 can clear it.
- R3: Guest status (guest offset 0) bits 0 and 1 are written by the guest and read on host offset 3 at bits 4 and 5. Host writes leave those two host bits unchanged.
- R4: Guest status bits 2 and 3 read control bits 6 and 7 and ignore guest writes. Guest status bits 7..4 are plain read/write.
- R5: Host offset 5, outside test mode, reads `hw_unlocked` at bit 5, `sw_video_rgb` at bit 2 and `sw_boot_pc` at bit 0, with 0 in every other bit. Host writes to offset 5 have no effect. Guest offset 2 always reads this switch byte.
- R6: With control bit 4 (test mode) set, successive host reads of offset 5 return D5, 7F, 00, AA, 55, FF, 80, 2A, repeating.
- R7: The sequence restarts at D5 each time test mode is entered. It moves only on a host read strobe of offset 5: idle cycles, other reads and guest reads leave it in place.
- R8: `guest_boot_map` follows control bit 1 and `video_sel` follows control bit 2. Each changes in the clock in which the control byte is written.
- R9: Host offset 1 always reads FF. `host_mem_at_zero` is 1 exactly when guest status bit 7 is 1 and control bit 0 is 0.
- R10: Write masks and reset values are as follows.

  | Offset | Reset value | Writable bits | Other bits |
  |---|---|---|---|
  | 0 | 00 | all | – |
  | 2 | CE | 4..1 | bits 7 and 6 read 1; bits 5 and 0 read 0 |
  | 3 | 00 | 7, 6, 3..0 | – |
  | 6 | 00 | 7..1 | bit 0 reads 0 |
  | 7 | 00 | 3..0 | bits 7..4 read 0 |

  `window_en` equals offset 3 bit 1.
- R11: When both buses write the control byte in the same clock, the guest value is stored for every bit.
- R12: Read data appears on `host_rdata` or `guest_rdata` in the clock after the edge that samples the read strobe. It holds its value until the next read on that bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered host read data |
| guest_addr | input | 2 | Guest register offset (0 status, 1 control, 2 switches) |
| guest_wdata | input | 8 | Guest write data |
| guest_wr | input | 1 | Guest write strobe |
| guest_rd | input | 1 | Guest read strobe |
| guest_rdata | output | 8 | Registered guest read data |
| sw_boot_pc | input | 1 | Boot-mode switch (0 console boot, 1 PC boot) |
| sw_video_rgb | input | 1 | Video-mode switch |
| hw_unlocked | input | 1 | Hardware-unlocked flag |
| guest_reset | output | 1 | Holds the guest CPU in reset |
| host_hold | output | 1 | Pauses the host CPU |
| video_sel | output | 1 | 0 host graphics, 1 console video |
| guest_boot_map | output | 1 | 1 expansion port, 0 boot ROM/host memory |
| window_en | output | 1 | Host memory window enable |
| host_mem_at_zero | output | 1 | Maps host memory at guest address 0 |

## Verification
The results fall due at three different points.
- Read data, including each test-sequence byte, is due one clock after the edge that samples the read strobe. The monitor pops the expected byte at that edge and compares it 2 ns later.
- `video_sel`, `guest_boot_map`, `window_en` and `host_mem_at_zero` come straight from stored bits. They are checked at the falling edge that follows the write edge.
- `guest_reset` and `host_hold` pass through the handoff state register. They are checked only after one further rising edge.

The sequence is read with idle cycles and guest reads placed between the host reads, so an advance on the wrong strobe would show up as a wrong byte.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

    localparam int DATA_W    = 8;
    localparam int HOST_AW   = 3;
    localparam int GUEST_AW  = 2;
    localparam int SEQ_LEN   = 8;
    localparam int SEQ_IW    = $clog2(SEQ_LEN);

    // host offsets whose behaviour is decoded
    localparam logic [HOST_AW-1:0] H_KEY    = 3'd0;
    localparam logic [HOST_AW-1:0] H_ONES   = 3'd1;
    localparam logic [HOST_AW-1:0] H_WBASE  = 3'd2;
    localparam logic [HOST_AW-1:0] H_MISC   = 3'd3;
    localparam logic [HOST_AW-1:0] H_CTRL   = 3'd4;
    localparam logic [HOST_AW-1:0] H_STAT   = 3'd5;
    localparam logic [HOST_AW-1:0] H_WLO    = 3'd6;
    localparam logic [HOST_AW-1:0] H_WHI    = 3'd7;

    // guest offsets
    localparam logic [GUEST_AW-1:0] G_STAT  = 2'd0;
    localparam logic [GUEST_AW-1:0] G_CTRL  = 2'd1;
    localparam logic [GUEST_AW-1:0] G_SW    = 2'd2;

    // write masks and fixed values
    localparam logic [DATA_W-1:0] WBASE_MASK  = 8'h1E;
    localparam logic [DATA_W-1:0] WBASE_FIXED = 8'hC0;
    localparam logic [DATA_W-1:0] WBASE_RST   = 8'hCE;
    localparam logic [DATA_W-1:0] MISC_MASK   = 8'hCF;
    localparam logic [DATA_W-1:0] WLO_MASK    = 8'hFE;
    localparam logic [DATA_W-1:0] WHI_MASK    = 8'h0F;
    localparam logic [DATA_W-1:0] GST_MASK    = 8'hF3;
    localparam logic [DATA_W-1:0] CTRL_RST    = 8'h80;

    // control byte bit positions
    localparam int C_RUN   = 0;
    localparam int C_BOOT  = 1;
    localparam int C_VID   = 2;
    localparam int C_TEST  = 4;
    localparam int C_GUEST_SEEN_LO = 6;
    localparam int C_STICKY = 7;

    typedef enum logic {
        HO_HOST_RUNS  = 1'b0,
        HO_GUEST_RUNS = 1'b1
    } handoff_t;

    typedef enum logic [3:0] {
        SQ_OFF = 4'b0000,
        SQ_E0  = 4'b1000,
        SQ_E1  = 4'b1001,
        SQ_E2  = 4'b1010,
        SQ_E3  = 4'b1011,
        SQ_E4  = 4'b1100,
        SQ_E5  = 4'b1101,
        SQ_E6  = 4'b1110,
        SQ_E7  = 4'b1111
    } seq_t;

    function automatic logic [DATA_W-1:0] seq_byte(input logic [SEQ_IW-1:0] idx);
        logic [DATA_W-1:0] b;
        unique case (idx)
            3'd0: b = 8'hD5;
            3'd1: b = 8'h7F;
            3'd2: b = 8'h00;
            3'd3: b = 8'hAA;
            3'd4: b = 8'h55;
            3'd5: b = 8'hFF;
            3'd6: b = 8'h80;
            3'd7: b = 8'h2A;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/handoff_fsm.sv
module handoff_fsm
    import handoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_guest,
    output logic guest_reset,
    output logic host_hold
);

    handoff_t state_q;
    handoff_t state_d;

    // next state: grant / reclaim
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HO_HOST_RUNS:  if (run_guest)  state_d = HO_GUEST_RUNS;
            HO_GUEST_RUNS: if (!run_guest) state_d = HO_HOST_RUNS;
            default:       state_d = HO_HOST_RUNS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HO_HOST_RUNS;
        else        state_q <= state_d;
    end

    // outputs decoded from the state only
    always_comb begin
        guest_reset = 1'b1;
        host_hold   = 1'b0;
        unique case (state_q)
            HO_HOST_RUNS: begin
                guest_reset = 1'b1;
                host_hold   = 1'b0;
            end
            HO_GUEST_RUNS: begin
                guest_reset = 1'b0;
                host_hold   = 1'b1;
            end
            default: begin
                guest_reset = 1'b1;
                host_hold   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/testseq_fsm.sv
module testseq_fsm
    import handoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              adv,
    output logic [3:0]        seq_state,
    output logic [DATA_W-1:0] seq_data
);

    seq_t state_q;
    seq_t state_d;

    function automatic seq_t step(input logic [SEQ_IW-1:0] idx);
        logic [SEQ_IW-1:0] nx;
        nx = idx + 1'b1;
        return seq_t'({1'b1, nx});
    endfunction

    // arm / step / quick step / disarm
    always_comb begin
        state_d = state_q;
        if (!test_en) begin
            state_d = SQ_OFF;
        end else begin
            unique case (state_q)
                SQ_OFF: state_d = adv ? SQ_E1 : SQ_E0;
                SQ_E0, SQ_E1, SQ_E2, SQ_E3,
                SQ_E4, SQ_E5, SQ_E6, SQ_E7:
                    if (adv) state_d = step(state_q[SEQ_IW-1:0]);
                default: state_d = SQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_OFF;
        else        state_q <= state_d;
    end

    // SQ_OFF presents entry 0 so a read in the first test cycle gets D5
    always_comb begin
        seq_state = state_q;
        unique case (state_q)
            SQ_OFF:  seq_data = seq_byte('0);
            default: seq_data = seq_byte(state_q[SEQ_IW-1:0]);
        endcase
    end

endmodule

// File: rtl/handoff_reg_bank.sv
module handoff_reg_bank
    import handoff_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_wr,
    input  logic [GUEST_AW-1:0] guest_addr,
    input  logic [DATA_W-1:0]   guest_wdata,
    input  logic                guest_wr,
    output logic [DATA_W-1:0]   key_q,
    output logic [DATA_W-1:0]   wbase_q,
    output logic [DATA_W-1:0]   misc_view,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic [DATA_W-1:0]   wlo_q,
    output logic [DATA_W-1:0]   whi_q,
    output logic [DATA_W-1:0]   gstat_q,
    output logic [DATA_W-1:0]   gstat_view
);

    logic [DATA_W-1:0] misc_q;
    logic h_key, h_wbase, h_misc, h_ctrl, h_wlo, h_whi;
    logic g_stat, g_ctrl;

    always_comb begin
        h_key   = host_wr && (host_addr == H_KEY);
        h_wbase = host_wr && (host_addr == H_WBASE);
        h_misc  = host_wr && (host_addr == H_MISC);
        h_ctrl  = host_wr && (host_addr == H_CTRL);
        h_wlo   = host_wr && (host_addr == H_WLO);
        h_whi   = host_wr && (host_addr == H_WHI);
        g_stat  = guest_wr && (guest_addr == G_STAT);
        g_ctrl  = guest_wr && (guest_addr == G_CTRL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            wbase_q <= WBASE_RST;
            misc_q  <= '0;
            wlo_q   <= '0;
            whi_q   <= '0;
        end else begin
            if (h_key)   key_q   <= host_wdata;
            if (h_wbase) wbase_q <= WBASE_FIXED | (host_wdata & WBASE_MASK);
            if (h_misc)  misc_q  <= host_wdata & MISC_MASK;
            if (h_wlo)   wlo_q   <= host_wdata & WLO_MASK;
            if (h_whi)   whi_q   <= host_wdata & WHI_MASK;
        end
    end

    // control byte: guest wins a collision; host may only set the sticky bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (g_ctrl) begin
            ctrl_q <= guest_wdata;
        end else if (h_ctrl) begin
            ctrl_q <= {ctrl_q[C_STICKY] | host_wdata[C_STICKY],
                       host_wdata[C_STICKY-1:0]};
        end
    end

    // guest private status: bits 3:2 are not stored
    always_ff @(posedge clk) begin
        if (!rst_n)      gstat_q <= '0;
        else if (g_stat) gstat_q <= guest_wdata & GST_MASK;
    end

    // composed views
    always_comb begin
        misc_view  = misc_q | {2'b00, gstat_q[1:0], 4'b0000};
        gstat_view = gstat_q | {4'b0000, ctrl_q[C_STICKY:C_GUEST_SEEN_LO], 2'b00};
    end

endmodule

// File: rtl/dual_cpu_handoff_regs.sv
module dual_cpu_handoff_regs
    import handoff_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_wr,
    input  logic                host_rd,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [GUEST_AW-1:0] guest_addr,
    input  logic [DATA_W-1:0]   guest_wdata,
    input  logic                guest_wr,
    input  logic                guest_rd,
    output logic [DATA_W-1:0]   guest_rdata,
    input  logic                sw_boot_pc,
    input  logic                sw_video_rgb,
    input  logic                hw_unlocked,
    output logic                guest_reset,
    output logic                host_hold,
    output logic                video_sel,
    output logic                guest_boot_map,
    output logic                window_en,
    output logic                host_mem_at_zero
);

    logic [DATA_W-1:0] key_q, wbase_q, misc_view, ctrl_q, wlo_q, whi_q;
    logic [DATA_W-1:0] gstat_q, gstat_view;
    logic [DATA_W-1:0] sw_byte, seq_data, host_mux, guest_mux;
    logic [3:0]        seq_state;
    logic              seq_adv;

    handoff_reg_bank i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_wr     (host_wr),
        .guest_addr  (guest_addr),
        .guest_wdata (guest_wdata),
        .guest_wr    (guest_wr),
        .key_q       (key_q),
        .wbase_q     (wbase_q),
        .misc_view   (misc_view),
        .ctrl_q      (ctrl_q),
        .wlo_q       (wlo_q),
        .whi_q       (whi_q),
        .gstat_q     (gstat_q),
        .gstat_view  (gstat_view)
    );

    handoff_fsm i_handoff (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_guest   (ctrl_q[C_RUN]),
        .guest_reset (guest_reset),
        .host_hold   (host_hold)
    );

    assign seq_adv = host_rd && (host_addr == H_STAT) && ctrl_q[C_TEST];

    testseq_fsm i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (ctrl_q[C_TEST]),
        .adv       (seq_adv),
        .seq_state (seq_state),
        .seq_data  (seq_data)
    );

    always_comb begin
        sw_byte = {2'b00, hw_unlocked, 2'b00, sw_video_rgb, 1'b0, sw_boot_pc};

        unique case (host_addr)
            H_KEY:   host_mux = key_q;
            H_ONES:  host_mux = '1;
            H_WBASE: host_mux = wbase_q;
            H_MISC:  host_mux = misc_view;
            H_CTRL:  host_mux = ctrl_q;
            H_STAT:  host_mux = ctrl_q[C_TEST] ? seq_data : sw_byte;
            H_WLO:   host_mux = wlo_q;
            H_WHI:   host_mux = whi_q;
            default: host_mux = '0;
        endcase

        unique case (guest_addr)
            G_STAT:  guest_mux = gstat_view;
            G_CTRL:  guest_mux = ctrl_q;
            G_SW:    guest_mux = sw_byte;
            default: guest_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            guest_rdata <= '0;
        end else begin
            if (host_rd)  host_rdata  <= host_mux;
            if (guest_rd) guest_rdata <= guest_mux;
        end
    end

    always_comb begin
        video_sel        = ctrl_q[C_VID];
        guest_boot_map   = ctrl_q[C_BOOT];
        window_en        = misc_view[1];
        host_mem_at_zero = gstat_q[DATA_W-1] & ~ctrl_q[C_RUN];
    end

endmodule

// File: rtl/handoff_regs_chk.sv
module handoff_regs_chk
    import handoff_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [HOST_AW-1:0]  host_addr,
    input logic                host_rd,
    input logic [DATA_W-1:0]   host_rdata,
    input logic [GUEST_AW-1:0] guest_addr,
    input logic                guest_wr,
    input logic                guest_reset,
    input logic                host_hold,
    input logic [DATA_W-1:0]   ctrl_q,
    input logic [DATA_W-1:0]   gstat_q,
    input logic [3:0]          seq_state
);

    a_r1_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[C_RUN] |=> (host_hold && !guest_reset));

    a_r1_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[C_RUN] |=> (guest_reset && !host_hold));

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        guest_reset != host_hold);

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_STICKY] && !(guest_wr && guest_addr == G_CTRL)) |=> ctrl_q[C_STICKY]);

    a_r3_guest_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(guest_wr && guest_addr == G_STAT) |=> $stable(gstat_q));

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == H_STAT && ctrl_q[C_TEST] && seq_state != 4'b0000)
        |=> seq_state != $past(seq_state));

    a_r9_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == H_ONES) |=> host_rdata == 8'hFF);

endmodule

bind dual_cpu_handoff_regs handoff_regs_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .guest_addr  (guest_addr),
    .guest_wr    (guest_wr),
    .guest_reset (guest_reset),
    .host_hold   (host_hold),
    .ctrl_q      (ctrl_q),
    .gstat_q     (gstat_q),
    .seq_state   (seq_state)
);

// File: tb/test_dual_cpu_handoff_regs.sv
`timescale 1ns/1ps
module test_dual_cpu_handoff_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [1:0] guest_addr = '0;
    logic [7:0] guest_wdata = '0;
    logic       guest_wr = 1'b0;
    logic       guest_rd = 1'b0;
    logic [7:0] guest_rdata;
    logic       sw_boot_pc = 1'b0;
    logic       sw_video_rgb = 1'b0;
    logic       hw_unlocked = 1'b0;
    logic       guest_reset, host_hold, video_sel, guest_boot_map;
    logic       window_en, host_mem_at_zero;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t hq[$];
    exp_t gq[$];

    always #4 clk = ~clk;

    dual_cpu_handoff_regs i_dual_cpu_handoff_regs (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .guest_addr(guest_addr), .guest_wdata(guest_wdata), .guest_wr(guest_wr),
        .guest_rd(guest_rd), .guest_rdata(guest_rdata),
        .sw_boot_pc(sw_boot_pc), .sw_video_rgb(sw_video_rgb), .hw_unlocked(hw_unlocked),
        .guest_reset(guest_reset), .host_hold(host_hold), .video_sel(video_sel),
        .guest_boot_map(guest_boot_map), .window_en(window_en),
        .host_mem_at_zero(host_mem_at_zero)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitors: the strobe seen at an edge is answered 2 ns later
    always @(posedge clk) begin
        if (host_rd && rst_n) begin
            exp_t e;
            if (hq.size() == 0) begin
                e.val = 8'hxx;
                e.tag = "R12 host unexpected read";
            end else begin
                e = hq.pop_front();
            end
            #2 chk(e.tag, host_rdata, e.val);
        end
    end

    always @(posedge clk) begin
        if (guest_rd && rst_n) begin
            exp_t e;
            if (gq.size() == 0) begin
                e.val = 8'hxx;
                e.tag = "R12 guest unexpected read";
            end else begin
                e = gq.pop_front();
            end
            #2 chk(e.tag, guest_rdata, e.val);
        end
    end

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic gwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        guest_addr = a; guest_wdata = d; guest_wr = 1'b1;
        @(negedge clk);
        guest_wr = 1'b0;
    endtask

    task automatic both_write(input logic [2:0] ha, input logic [7:0] hd,
                              input logic [1:0] ga, input logic [7:0] gd);
        @(negedge clk);
        host_addr = ha; host_wdata = hd; host_wr = 1'b1;
        guest_addr = ga; guest_wdata = gd; guest_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; guest_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.val = exp; e.tag = tag;
        hq.push_back(e);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic gread(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.val = exp; e.tag = tag;
        gq.push_back(e);
        guest_addr = a; guest_rd = 1'b1;
        @(negedge clk);
        guest_rd = 1'b0;
    endtask

    // one more rising edge so the handoff state register has updated
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset guest_reset", {7'b0, guest_reset}, 8'h01);
        chk("R1 reset host_hold", {7'b0, host_hold}, 8'h00);
        hread(3'd0, 8'h00, "R10 reset key");
        hread(3'd1, 8'hFF, "R9 ones at reset");
        hread(3'd2, 8'hCE, "R10 reset window base");
        hread(3'd3, 8'h00, "R10 reset misc");
        hread(3'd4, 8'h80, "R2 control resets with bit7");
        hread(3'd5, 8'h00, "R5 switches all low");
        hread(3'd6, 8'h00, "R10 reset window low");
        hread(3'd7, 8'h00, "R10 reset window high");

        // write masks
        hwrite(3'd0, 8'h5A); hread(3'd0, 8'h5A, "R10 key all bits");
        hwrite(3'd2, 8'hFF); hread(3'd2, 8'hDE, "R10 window base mask ones");
        hwrite(3'd2, 8'h00); hread(3'd2, 8'hC0, "R10 window base mask zeros");
        hwrite(3'd6, 8'hFF); hread(3'd6, 8'hFE, "R10 window low mask");
        hwrite(3'd7, 8'hFF); hread(3'd7, 8'h0F, "R10 window high mask");
        hwrite(3'd1, 8'h00); hread(3'd1, 8'hFF, "R9 ones after write");
        hwrite(3'd3, 8'hFF);
        chk("R10 window_en set", {7'b0, window_en}, 8'h01);
        hread(3'd3, 8'hCF, "R3 misc host bits 5:4 read-only");
        hwrite(3'd3, 8'h00);
        chk("R10 window_en clear", {7'b0, window_en}, 8'h00);

        // sticky bit and handoff
        hwrite(3'd4, 8'h00); hread(3'd4, 8'h80, "R2 host cannot clear bit7");
        hwrite(3'd4, 8'h87);
        chk("R8 video_sel on", {7'b0, video_sel}, 8'h01);
        chk("R8 boot map on", {7'b0, guest_boot_map}, 8'h01);
        settle();
        chk("R1 grant guest_reset", {7'b0, guest_reset}, 8'h00);
        chk("R1 grant host_hold", {7'b0, host_hold}, 8'h01);
        hwrite(3'd4, 8'h00);
        chk("R8 video_sel off", {7'b0, video_sel}, 8'h00);
        chk("R8 boot map off", {7'b0, guest_boot_map}, 8'h00);
        settle();
        chk("R1 reclaim guest_reset", {7'b0, guest_reset}, 8'h01);
        chk("R1 reclaim host_hold", {7'b0, host_hold}, 8'h00);
        gwrite(2'd1, 8'h00); hread(3'd4, 8'h00, "R2 guest clears bit7");
        gread(2'd1, 8'h00, "R2 guest view of control");
        hwrite(3'd4, 8'h80); hread(3'd4, 8'h80, "R2 host sets bit7");
        gwrite(2'd1, 8'h01); settle();
        chk("R1 guest-written grant", {7'b0, host_hold}, 8'h01);
        gwrite(2'd1, 8'h80); settle();
        chk("R1 guest-written reclaim", {7'b0, guest_reset}, 8'h01);

        // mailbox and reflected bits
        gwrite(2'd0, 8'hFF);
        hread(3'd3, 8'h30, "R3 guest bits on host 5:4");
        hwrite(3'd3, 8'h00);
        hread(3'd3, 8'h30, "R3 host write leaves 5:4");
        gread(2'd0, 8'hF8 | 8'h03, "R4 guest status with ctrl 80");
        hwrite(3'd4, 8'h40);
        gread(2'd0, 8'hFF, "R4 guest status with ctrl C0");
        gwrite(2'd0, 8'h01);
        hread(3'd3, 8'h10, "R3 single mailbox bit");
        gread(2'd0, 8'h0D, "R4 guest writes to 3:2 ignored");
        chk("R9 mem at zero off", {7'b0, host_mem_at_zero}, 8'h00);
        gwrite(2'd0, 8'h80);
        chk("R9 mem at zero on", {7'b0, host_mem_at_zero}, 8'h01);
        hwrite(3'd4, 8'hC1);
        chk("R9 mem at zero blocked by run", {7'b0, host_mem_at_zero}, 8'h00);
        hwrite(3'd4, 8'hC0);

        // switch inputs
        @(negedge clk); sw_boot_pc = 1'b1;
        hread(3'd5, 8'h01, "R5 boot switch");
        @(negedge clk); sw_boot_pc = 1'b0; sw_video_rgb = 1'b1;
        hread(3'd5, 8'h04, "R5 video switch");
        @(negedge clk); sw_video_rgb = 1'b0; hw_unlocked = 1'b1;
        hread(3'd5, 8'h20, "R5 unlocked flag");
        @(negedge clk); sw_boot_pc = 1'b1; sw_video_rgb = 1'b1;
        hwrite(3'd5, 8'hFF);
        hread(3'd5, 8'h25, "R5 all inputs and write ignored");
        gread(2'd2, 8'h25, "R5 guest switch view");

        // test sequence
        hwrite(3'd4, 8'hD0);
        hread(3'd5, 8'hD5, "R6 seq 0");
        hread(3'd5, 8'h7F, "R6 seq 1");
        hread(3'd5, 8'h00, "R6 seq 2");
        gread(2'd2, 8'h25, "R7 guest read in test mode");
        repeat (3) @(negedge clk);
        hread(3'd4, 8'hD0, "R7 other host read");
        hread(3'd5, 8'hAA, "R7 seq 3 after idle and guest read");
        hread(3'd5, 8'h55, "R6 seq 4");
        hread(3'd5, 8'hFF, "R6 seq 5");
        hread(3'd5, 8'h80, "R6 seq 6");
        hread(3'd5, 8'h2A, "R6 seq 7");
        hread(3'd5, 8'hD5, "R6 seq wraps");
        hread(3'd5, 8'h7F, "R6 seq 1 again");
        hwrite(3'd4, 8'hC0);
        hread(3'd5, 8'h25, "R5 switches back after test");
        hwrite(3'd4, 8'hD0);
        repeat (2) @(negedge clk);
        hread(3'd5, 8'hD5, "R7 restart on re-entry");
        hwrite(3'd4, 8'hC0);

        // read data hold
        hread(3'd0, 8'h5A, "R12 key read");
        repeat (4) @(negedge clk);
        chk("R12 host data held", host_rdata, 8'h5A);
        chk("R12 guest data held", guest_rdata, 8'h25);

        // collision
        both_write(3'd4, 8'h04, 2'd1, 8'h02);
        chk("R11 collision boot map", {7'b0, guest_boot_map}, 8'h01);
        chk("R11 collision video", {7'b0, video_sel}, 8'h00);
        hread(3'd4, 8'h02, "R11 guest value stored");

        repeat (4) @(negedge clk);
        if (hq.size() != 0 || gq.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R12 queues not drained: actual %0d expected 0", hq.size() + gq.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule